// File: doc/BRIEF.md
# Latched Interval Timer with Interrupt

This block is a 16-bit down-counting interval timer inside a byte-wide peripheral register bank. A host writes a start value into two latch bytes. Writing the high byte of the counter copies the whole latch into the counter and starts a new interval. The counter moves down by one on every cycle in which the tick enable input is high. When it steps past zero, the timer raises its interrupt flag.

In continuous mode the counter reloads itself from the latch every time it expires, so the flag is raised every latch + 1 ticks. In one-shot mode the flag is raised only once per start, and the counter then wraps and keeps running. A flag register and an enable register combine into a level interrupt output. All host access is a single-cycle byte write. The read data is combinational on the address.

Top module: `latched_interval_timer`

## Requirements
- R1: After reset both latch bytes read 0xFF, the mode register (index 11) and the flag register (index 13) read 0x00, the enable register (index 14) reads 0x80, and `irq_out` is low.
- R2: A write to index 4, or to index 6, stores the byte into the low latch byte and into bits 7:0 of the counter. The counter does not decrement in that cycle, and the upper counter byte is kept.
- R3: A write to index 5 stores the byte into the high latch byte. It loads the counter with {written byte, low latch byte}, clears the flag (bit 6 of index 13) and arms a one-shot start. The counter does not decrement in that cycle.
- R4: A write to index 7 changes only the high latch byte. The counter keeps counting, and the next reload uses the new value.
- R5: Reads return:
  - index 4 and index 5: the live counter, low and high byte;
  - index 6 and index 7: the latch bytes;
  - index 11: the mode byte;
  - any unmapped index: 0x00.
  Writes to unmapped indices have no effect.
- R6: On a tick while the counter is not zero, the counter drops by one. On a tick at zero with mode bit 6 set (continuous), the counter reloads from the latch and the flag is set. The interval is therefore latch + 1 ticks.
- R7: With mode bit 6 clear (one-shot), a tick at zero sets the flag only if the timer was armed by an index 5 write since the last expiry. The counter then wraps to 0xFFFF and keeps counting without setting the flag again.
- R8: A write to index 13 with bit 6 set clears the flag, and a write with bit 6 clear leaves it unchanged. If an expiry happens in the same cycle, the flag stays set. Index 13 reads back the flag in bit 6 and the interrupt state in bit 7, with all other bits 0.
- R9: A write to index 14 with bit 7 set sets every enable bit written as 1. A write with bit 7 clear clears every enable bit written as 1. Index 14 reads back the enables with bit 7 forced to 1.
- R10: `irq_out` is high exactly when the flag and enable bit 6 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| host_wr | input | 1 | Byte write strobe |
| host_addr | input | ADDR_W | Register index for reads and writes |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for `host_addr` |
| irq_out | output | 1 | Level interrupt request |

## Verification
The counter is driven three ways: with a tick on every cycle, with a sparse tick on every third cycle, and with writes that land in the same cycle as a tick. These patterns separate the decrement itself from the rule that a write blocks the tick. The same interval is run in continuous mode and in one-shot mode. Comparing the two shows whether the reload and the flag follow the mode bit and the arm state. Collisions between a flag clear and an expiry, and between a high-latch write and a live count, test the priority rules on their own.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int IDX_CNT_LO  = 4;
    localparam int IDX_CNT_HI  = 5;
    localparam int IDX_LAT_LO  = 6;
    localparam int IDX_LAT_HI  = 7;
    localparam int IDX_MODE    = 11;
    localparam int IDX_FLAG    = 13;
    localparam int IDX_ENABLE  = 14;

    // bit of the flag/enable registers owned by this timer
    localparam int TMR_BIT     = 6;
    // bit of the mode register that selects continuous operation
    localparam int CONT_BIT    = 6;

    typedef struct packed {
        logic lo_wr;      // index 4 or 6
        logic cnt_hi_wr;  // index 5
        logic lat_hi_wr;  // index 7
        logic mode_wr;    // index 11
        logic flag_wr;    // index 13
        logic en_wr;      // index 14
    } tmr_wr_t;

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [CNT_W-1:0]  latch_val,
    input  logic              flag_val,
    input  logic [DATA_W-2:0] en_val,
    input  logic              irq_val,
    output tmr_wr_t           wr_str,
    output logic              cont_mode,
    output logic [DATA_W-1:0] host_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] mode;
    } dec_state_t;

    dec_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        wr_str = '0;
        if (host_wr) begin
            unique case (int'(host_addr))
                IDX_CNT_LO, IDX_LAT_LO: wr_str.lo_wr     = 1'b1;
                IDX_CNT_HI:             wr_str.cnt_hi_wr = 1'b1;
                IDX_LAT_HI:             wr_str.lat_hi_wr = 1'b1;
                IDX_MODE:               wr_str.mode_wr   = 1'b1;
                IDX_FLAG:               wr_str.flag_wr   = 1'b1;
                IDX_ENABLE:             wr_str.en_wr     = 1'b1;
                default:                ;
            endcase
        end
        if (wr_str.mode_wr) begin
            s_d.mode = host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cont_mode = s_q.mode[CONT_BIT];

    always_comb begin
        host_rdata = '0;
        unique case (int'(host_addr))
            IDX_CNT_LO: host_rdata = cnt_val[DATA_W-1:0];
            IDX_CNT_HI: host_rdata = cnt_val[CNT_W-1:DATA_W];
            IDX_LAT_LO: host_rdata = latch_val[DATA_W-1:0];
            IDX_LAT_HI: host_rdata = latch_val[CNT_W-1:DATA_W];
            IDX_MODE:   host_rdata = s_q.mode;
            IDX_FLAG: begin
                host_rdata[TMR_BIT]    = flag_val;
                host_rdata[DATA_W-1]   = irq_val;
            end
            IDX_ENABLE: host_rdata = {1'b1, en_val};
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  tmr_wr_t           wr_str,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cont_mode,
    output logic [CNT_W-1:0]  cnt_val,
    output logic [CNT_W-1:0]  latch_val,
    output logic              fire,
    output logic              restart
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] lat_lo;
        logic [DATA_W-1:0] lat_hi;
        logic              armed;
    } core_state_t;

    core_state_t s_q, s_d;
    logic        tick_eff;
    logic        at_zero;

    always_comb begin
        s_d      = s_q;
        tick_eff = tick_en && !(wr_str.lo_wr || wr_str.cnt_hi_wr);
        at_zero  = (s_q.cnt == '0);
        fire     = tick_eff && at_zero && (cont_mode || s_q.armed);

        if (tick_eff) begin
            if (at_zero) begin
                s_d.cnt   = cont_mode ? {s_q.lat_hi, s_q.lat_lo} : '1;
                s_d.armed = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        if (wr_str.lo_wr) begin
            s_d.lat_lo           = wdata;
            s_d.cnt[DATA_W-1:0]  = wdata;
        end
        if (wr_str.lat_hi_wr) begin
            s_d.lat_hi = wdata;
        end
        if (wr_str.cnt_hi_wr) begin
            s_d.lat_hi = wdata;
            s_d.cnt    = {wdata, s_q.lat_lo};
            s_d.armed  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt    <= '0;
            s_q.lat_lo <= '1;
            s_q.lat_hi <= '1;
            s_q.armed  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_val   = s_q.cnt;
    assign latch_val = {s_q.lat_hi, s_q.lat_lo};
    assign restart   = wr_str.cnt_hi_wr;

endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_wr_t           wr_str,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fire,
    input  logic              restart,
    output logic              flag_val,
    output logic [DATA_W-2:0] en_val,
    output logic              irq_val
);

    typedef struct packed {
        logic              flag;
        logic [DATA_W-2:0] en;
    } irq_state_t;

    irq_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.flag = 1'b0;
        end
        if (wr_str.flag_wr && wdata[TMR_BIT]) begin
            s_d.flag = 1'b0;
        end
        if (fire) begin
            s_d.flag = 1'b1;
        end
        if (wr_str.en_wr) begin
            if (wdata[DATA_W-1]) begin
                s_d.en = s_q.en | wdata[DATA_W-2:0];
            end else begin
                s_d.en = s_q.en & ~wdata[DATA_W-2:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_val = s_q.flag;
    assign en_val   = s_q.en;
    assign irq_val  = s_q.flag && s_q.en[TMR_BIT];

endmodule

// File: rtl/latched_interval_timer.sv
module latched_interval_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_out
);

    localparam int CNT_W = 2 * DATA_W;

    tmr_wr_t           wr_str;
    logic              cont_mode;
    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  latch_val;
    logic              fire;
    logic              restart;
    logic              flag_val;
    logic [DATA_W-2:0] en_val;
    logic              irq_val;

    tmr_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .cnt_val    (cnt_val),
        .latch_val  (latch_val),
        .flag_val   (flag_val),
        .en_val     (en_val),
        .irq_val    (irq_val),
        .wr_str     (wr_str),
        .cont_mode  (cont_mode),
        .host_rdata (host_rdata)
    );

    tmr_count_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_str    (wr_str),
        .wdata     (host_wdata),
        .cont_mode (cont_mode),
        .cnt_val   (cnt_val),
        .latch_val (latch_val),
        .fire      (fire),
        .restart   (restart)
    );

    tmr_irq_unit #(.DATA_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_str   (wr_str),
        .wdata    (host_wdata),
        .fire     (fire),
        .restart  (restart),
        .flag_val (flag_val),
        .en_val   (en_val),
        .irq_val  (irq_val)
    );

    assign irq_out = irq_val;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              irq_out,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  latch_val,
    input logic              flag_val,
    input logic              cont_mode
);

    logic wr_hi, wr_lathi, wr_lo, wr_flag;
    assign wr_hi    = host_wr && (int'(host_addr) == 5);
    assign wr_lathi = host_wr && (int'(host_addr) == 7);
    assign wr_lo    = host_wr && (int'(host_addr) == 4 || int'(host_addr) == 6);
    assign wr_flag  = host_wr && (int'(host_addr) == 13);

    p_load_on_hi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> cnt_val == {$past(host_wdata), $past(latch_val[DATA_W-1:0])});

    p_hi_write_clears_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> !irq_out);

    p_lathi_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lathi && !tick_en) |=> cnt_val == $past(cnt_val));

    p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_hi && !wr_lo && cnt_val != '0) |=> cnt_val == $past(cnt_val) - 1'b1);

    p_reload_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_hi && !wr_lo && cnt_val == '0 && cont_mode) |=>
            (cnt_val == $past(latch_val) && flag_val));

    p_oneshot_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_hi && !wr_lo && cnt_val == '0 && !cont_mode) |=> cnt_val == '1);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && host_wdata[6] && !(tick_en && cnt_val == '0)) |=> !flag_val);

endmodule

bind latched_interval_timer tmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .irq_out    (irq_out),
    .cnt_val    (cnt_val),
    .latch_val  (latch_val),
    .flag_val   (flag_val),
    .cont_mode  (cont_mode)
);

// File: tb/latched_interval_timer_test.sv
module latched_interval_timer_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       host_wr = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt, m_llo, m_lhi, m_mode, m_en;
    bit m_flag, m_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_out(irq_out)
    );

    function automatic bit m_irq();
        return m_flag && m_en[6];
    endfunction

    function automatic int m_read(int a);
        case (a)
            4: return m_cnt & 255;
            5: return (m_cnt >> 8) & 255;
            6: return m_llo;
            7: return m_lhi;
            11: return m_mode;
            13: return (int'(m_irq()) << 7) | (int'(m_flag) << 6);
            14: return 128 | m_en;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_llo = 255; m_lhi = 255; m_mode = 0; m_en = 0;
        m_flag = 0; m_armed = 0;
    endtask

    task automatic model_step();
        int a = int'(host_addr);
        int d = int'(host_wdata);
        bit wl = host_wr && (a == 4 || a == 6);
        bit wh = host_wr && a == 5;
        bit teff = tick_en && !wl && !wh;
        bit fire = 0;
        int old_latch = (m_lhi << 8) | m_llo;
        if (teff) begin
            if (m_cnt == 0) begin
                fire = m_mode[6] || m_armed;
                m_cnt = m_mode[6] ? old_latch : 65535;
                m_armed = 0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        if (host_wr) begin
            case (a)
                4, 6: begin m_llo = d; m_cnt = (m_cnt & 16'hFF00) | d; end
                5: begin m_lhi = d; m_cnt = (d << 8) | m_llo; m_flag = 0; m_armed = 1; end
                7: m_lhi = d;
                11: m_mode = d;
                13: if (d[6]) m_flag = 0;
                14: if (d[7]) m_en = m_en | (d & 127); else m_en = m_en & ~(d & 127);
                default: ;
            endcase
        end
        if (fire) m_flag = 1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(int a);
        case (a)
            4, 5: return "R6 count";
            6, 7: return "R2/R4 latch";
            11: return "R5 mode";
            13: return "R8 flag";
            14: return "R9 enable";
            default: return "R5 unmapped";
        endcase
    endfunction

    // one clock: drive, model at edge, compare after edge
    task automatic cyc(bit wr, int a, int d, bit t);
        host_wr = wr; host_addr = 4'(a); host_wdata = 8'(d); tick_en = t;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R10 irq", int'(irq_out), int'(m_irq()));
        chk(tag_of(int'(host_addr)), int'(host_rdata), m_read(int'(host_addr)));
    endtask

    task automatic wr(int a, int d);
        cyc(1, a, d, 0);
    endtask

    task automatic idle(int a, bit t);
        cyc(0, a, 0, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ticks;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        idle(6, 0); chk("R1 latch lo", int'(host_rdata), 255);
        idle(7, 0); chk("R1 latch hi", int'(host_rdata), 255);
        idle(11, 0); chk("R1 mode", int'(host_rdata), 0);
        idle(13, 0); chk("R1 flag", int'(host_rdata), 0);
        idle(14, 0); chk("R1 enable", int'(host_rdata), 128);
        chk("R1 irq", int'(irq_out), 0);

        // R6: continuous mode, interval latch+1 with a tick every cycle
        wr(11, 8'h40);
        wr(14, 8'hC0);
        wr(4, 5);
        wr(5, 0);
        ticks = 0;
        for (int i = 0; i < 12 && !irq_out; i++) begin
            idle(4, 1);
            ticks++;
        end
        chk("R6 ticks to expiry", ticks, 6);
        chk("R6 reload", int'(m_cnt), 5);
        for (int i = 0; i < 15; i++) idle(4, 1);

        // R8: clear by writing 0 (no effect), then 1
        wr(13, 8'h00);
        chk("R8 zero write keeps flag", int'(m_flag), 1);
        idle(13, 0);
        wr(13, 8'h40);
        idle(13, 0); chk("R8 flag cleared", int'(host_rdata), 0);

        // R8: clear write collides with expiry
        wr(4, 2); wr(5, 0);
        idle(4, 1); idle(4, 1);
        cyc(1, 13, 8'h40, 1);
        chk("R8 expiry wins", int'(irq_out), 1);

        // R9/R10: enable clear masks irq
        wr(14, 8'h40);
        idle(14, 0); chk("R9 enable read", int'(host_rdata), 128);
        chk("R10 irq masked", int'(irq_out), 0);
        wr(14, 8'hC0);
        chk("R10 irq restored", int'(irq_out), 1);

        // R7: one-shot fires once, then wraps
        wr(11, 8'h00);
        wr(4, 3); wr(5, 0);
        for (int i = 0; i < 5; i++) idle(4, 1);
        chk("R7 one-shot fired", int'(irq_out), 1);
        wr(13, 8'h40);
        idle(5, 0); chk("R7 wrapped hi", int'(host_rdata), 255);
        for (int i = 0; i < 20; i++) idle(13, 1);
        chk("R7 no second flag", int'(irq_out), 0);

        // R4: high latch write during a live count
        wr(11, 8'h40);
        wr(4, 4); wr(5, 0);
        idle(4, 1);
        cyc(1, 7, 1, 1);
        idle(5, 0); chk("R4 count hi unchanged", int'(host_rdata), 0);
        for (int i = 0; i < 4; i++) idle(5, 1);
        chk("R4 reload uses new hi", int'(host_rdata), 1);

        // R2: low write while counting, with colliding tick
        cyc(1, 6, 8'h33, 1);
        idle(4, 0); chk("R2 low byte", int'(host_rdata), 8'h33);
        idle(5, 0); chk("R2 hi kept", int'(host_rdata), 1);
        cyc(1, 4, 8'h10, 1);
        idle(6, 0); chk("R2 alias latch", int'(host_rdata), 8'h10);

        // R3: restart with colliding tick clears flag
        cyc(1, 5, 0, 1);
        idle(4, 0); chk("R3 load lo", int'(host_rdata), 8'h10);
        chk("R3 flag clear", int'(irq_out), 0);

        // R5: unmapped write ignored
        wr(2, 8'hAA);
        idle(2, 0); chk("R5 unmapped read", int'(host_rdata), 0);
        idle(11, 0); chk("R5 mode intact", int'(host_rdata), 8'h40);

        // sparse ticks, every third cycle
        wr(4, 7); wr(5, 0);
        for (int i = 0; i < 60; i++) idle((i % 2) ? 4 : 13, (i % 3) == 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule